// File: doc/BRIEF.md
# Cascadable Event Counter Bank

The block holds six 16-bit down-counters split into two groups of three. Each counter advances on events chosen by its own 8-bit mode register. The event source is one of two things. The first is a chosen edge of the counter's own external input; that input passes through a synchroniser before its edges are detected. The second is the one-cycle underflow pulse of the previous counter in a fixed ring of three within the same group. Each counter counts down from a reload value. When an event arrives while the counter is at zero, the counter reloads and raises a one-cycle underflow pulse. That pulse is available at the block's pins and is also fed to the next counter in the ring.

Software reaches every counter through a simple single-cycle register port. The address is split as follows: bits [4:2] select the channel (0 to 5) and bits [1:0] select the field. Field 0 is the mode register, field 1 is the reload value, field 2 is the current count (read only) and field 3 is the start bit (bit 0). Reads are combinational. Writes take effect at the clock edge. An address with a channel index of 6 or 7 reads as zero, and writes to it are dropped.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every mode register reads 0x00, every reload value, count and start bit reads 0, and every underflow output is low.
- R2: In the mode register, bits [1:0] (operation), [3:2] (edge select), 6 (spare) and 7 (source select) are stored and read back; bits [5:4] always read 0 and writes to them are ignored.
- R3: With source select 0 and edge select 00, each falling edge of the channel's input decrements the count by one, and rising edges do nothing.
- R4: With source select 0 and edge select 01, each rising edge decrements the count by one, and falling edges do nothing.
- R5: With source select 0 and edge select 10, both edges decrement the count. The input is synchronised by two flops, so the count changes on the third rising clock edge after the input changes, and one input change gives exactly one step.
- R6: With source select 0 and edge select 11, no input edge changes the count.
- R7: With source select 1 the event is the underflow pulse of channel i-1, except that channel 0 takes channel 2 and channel 3 takes channel 5. The edge select field is ignored in this case, and the step lands one cycle after the source pulse.
- R8: The count holds unless the start bit is 1 and operation bits [1:0] are 01.
- R9: An event taken at count 0 loads the reload value and drives that channel's underflow output high for exactly one cycle. Any other event decrements the count by one.
- R10: A reload write while the start bit is 0 also loads the count. While the start bit is 1 the write updates only the reload value. If that write coincides with an underflow, the count takes the newly written value.
- R11: Mode bit 6 is writable and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_pin_i | input | 6 | External event inputs, one per channel (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address: channel [4:2], field [1:0] |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| uflow_o | output | 6 | One-cycle underflow pulse per channel |

## Verification
An underflow reload and a software reload write can land in the same cycle, and the resulting count depends on which of them wins. The bench produces this collision on a running channel at count zero. It changes the input pin, then places the reload write on the exact edge where the synchronised event is taken, which is the third rising edge after the pin change. The collision passes if the count equals the newly written value while the underflow pulse is high. A second write on the same running channel, away from any event, must then leave the count unchanged.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam logic [1:0] OP_EVENT = 2'b01;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      src_casc;
    logic      spare;
    logic [1:0] rsvd;
    edge_sel_e edge_sel;
    logic [1:0] op;
  } mode_t;

  typedef enum logic [1:0] {
    FLD_MODE   = 2'd0,
    FLD_RELOAD = 2'd1,
    FLD_COUNT  = 2'd2,
    FLD_START  = 2'd3
  } fld_e;

  // previous member of the ring inside a group
  function automatic int ring_src(input int ch, input int gsize);
    return ((ch % gsize) == 0) ? ch + gsize - 1 : ch - 1;
  endfunction
endpackage

// File: rtl/evb_edge_sync.sv
module evb_edge_sync #(
  parameter int N      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R5: one input change gives a single detection pulse
  assert_one_pulse_per_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_o & $past(rise_o)) == '0) && ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/evb_chan.sv
module evb_chan
  import evb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              reload_we_i,
  input  logic              start_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pin_rise_i,
  input  logic              pin_fall_i,
  input  logic              casc_evt_i,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              start_o,
  output logic              uflow_o
);
  mode_t            mode_q;
  logic [CNT_W-1:0] reload_q, count_q, reload_nxt;
  logic             start_q, uflow_q, evt, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (mode_we_i) begin
        mode_q          <= mode_t'(wdata_i[7:0]);
        mode_q.rsvd     <= 2'b00;
      end
      if (start_we_i) start_q <= wdata_i[0];
    end
  end

  always_comb begin
    if (mode_q.src_casc) evt = casc_evt_i;
    else begin
      unique case (mode_q.edge_sel)
        EDGE_FALL: evt = pin_fall_i;
        EDGE_RISE: evt = pin_rise_i;
        EDGE_BOTH: evt = pin_rise_i | pin_fall_i;
        default:   evt = 1'b0;
      endcase
    end
  end

  assign step       = start_q && (mode_q.op == OP_EVENT) && evt;
  assign reload_nxt = reload_we_i ? wdata_i[CNT_W-1:0] : reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      count_q  <= '0;
      uflow_q  <= 1'b0;
    end else begin
      reload_q <= reload_nxt;
      uflow_q  <= 1'b0;
      if (step) begin
        if (count_q == '0) begin
          count_q <= reload_nxt;
          uflow_q <= 1'b1;
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end else if (reload_we_i && !start_q) begin
        count_q <= wdata_i[CNT_W-1:0];
      end
    end
  end

  assign mode_o   = mode_q;
  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign start_o  = start_q;
  assign uflow_o  = uflow_q;

  assert_uflow_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_q |-> (count_q == reload_q));

  assert_hold_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && !reload_we_i) |=> $stable(count_q));

  assert_hold_mode_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q.op != OP_EVENT) && !reload_we_i) |=> $stable(count_q));

  assert_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_we_i |=> (count_q == $past(count_q)) ||
                     (count_q == $past(count_q) - CNT_W'(1)) || uflow_q);
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evb_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GROUP_SIZE = 3,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CH    = NUM_GROUPS * GROUP_SIZE,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ADDR_W    = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] uflow_o
);
  logic [NUM_CH-1:0] rise, fall, uflow;
  logic [CH_W-1:0]   ch_sel;
  fld_e              fld;
  mode_t             mode_a   [NUM_CH];
  logic [CNT_W-1:0]  reload_a [NUM_CH];
  logic [CNT_W-1:0]  count_a  [NUM_CH];
  logic              start_a  [NUM_CH];

  assign ch_sel = reg_addr_i[ADDR_W-1:2];
  assign fld    = fld_e'(reg_addr_i[1:0]);

  evb_edge_sync #(.N(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit = reg_we_i && (ch_sel == CH_W'(k));

    evb_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_we_i   (hit && fld == FLD_MODE),
      .reload_we_i (hit && fld == FLD_RELOAD),
      .start_we_i  (hit && fld == FLD_START),
      .wdata_i     (reg_wdata_i),
      .pin_rise_i  (rise[k]),
      .pin_fall_i  (fall[k]),
      .casc_evt_i  (uflow[ring_src(k, GROUP_SIZE)]),
      .mode_o      (mode_a[k]),
      .reload_o    (reload_a[k]),
      .count_o     (count_a[k]),
      .start_o     (start_a[k]),
      .uflow_o     (uflow[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel == CH_W'(k)) begin
        unique case (fld)
          FLD_MODE:   reg_rdata_o = DATA_W'(mode_a[k]);
          FLD_RELOAD: reg_rdata_o = DATA_W'(reload_a[k]);
          FLD_COUNT:  reg_rdata_o = DATA_W'(count_a[k]);
          default:    reg_rdata_o = DATA_W'(start_a[k]);
        endcase
      end
    end
  end

  assign uflow_o = uflow;

  // R2: reserved mode bits never read back as set
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld == FLD_MODE) |-> (reg_rdata_o[5:4] == 2'b00));
endmodule

// File: tb/evt_counter_bank_bench.sv
module evt_counter_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pin = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  uflow;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  evt_counter_bank u_evt_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .uflow_o(uflow)
  );

  function automatic logic [4:0] a(input int ch, input int f);
    return {3'(ch), 2'(f)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int f, input int d);
    we = 1'b1; addr = a(ch, f); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int ch, input int f, output int v);
    addr = a(ch, f); #0.5; v = int'(rdata);
  endtask

  task automatic set_pin(input int ch, input logic v);
    pin[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset;
    we = 1'b0; pin = '0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input int ch, input int mode, input int rl);
    wr(ch, 0, mode); wr(ch, 1, rl); wr(ch, 3, 1);
  endtask

  task automatic t_reset;
    int v;
    do_reset();
    for (int c = 0; c < 6; c++) begin
      rd(c, 0, v); chk("R1 mode", v, 0);
      rd(c, 2, v); chk("R1 count", v, 0);
      rd(c, 3, v); chk("R1 start", v, 0);
    end
    chk("R1 uflow", int'(uflow), 0);
  endtask

  task automatic t_mode_rw;
    int v;
    do_reset();
    wr(1, 0, 16'h00FF); rd(1, 0, v); chk("R2 mode ff", v, 'hCF);
    wr(4, 0, 16'h0035); rd(4, 0, v); chk("R2 mode 35", v, 'h05);
    rd(7, 0, v); chk("R2 bad channel", v, 0);
  endtask

  task automatic t_fall;
    int v;
    do_reset(); setup(1, 'h01, 5);
    set_pin(1, 1); rd(1, 2, v); chk("R3 rise ignored", v, 5);
    set_pin(1, 0); rd(1, 2, v); chk("R3 fall counts", v, 4);
  endtask

  task automatic t_rise;
    int v;
    do_reset(); setup(2, 'h05, 5);
    set_pin(2, 1); rd(2, 2, v); chk("R4 rise counts", v, 4);
    set_pin(2, 0); rd(2, 2, v); chk("R4 fall ignored", v, 4);
  endtask

  task automatic t_both;
    int v;
    do_reset(); setup(4, 'h09, 7);
    pin[4] = 1'b1;
    @(posedge clk); @(posedge clk); #1; rd(4, 2, v); chk("R5 not before 3rd edge", v, 7);
    @(posedge clk); #1; rd(4, 2, v); chk("R5 at 3rd edge", v, 6);
    repeat (3) @(negedge clk); rd(4, 2, v); chk("R5 single step", v, 6);
    set_pin(4, 0); rd(4, 2, v); chk("R5 fall counts", v, 5);
  endtask

  task automatic t_rsvd;
    int v;
    do_reset(); setup(3, 'h0D, 6);
    set_pin(3, 1); set_pin(3, 0); rd(3, 2, v); chk("R6 edges ignored", v, 6);
  endtask

  task automatic t_gate;
    int v;
    do_reset();
    wr(0, 0, 'h05); wr(0, 1, 4);
    set_pin(0, 1); set_pin(0, 0); rd(0, 2, v); chk("R8 stopped holds", v, 4);
    wr(0, 3, 1); wr(0, 0, 'h04);
    set_pin(0, 1); set_pin(0, 0); rd(0, 2, v); chk("R8 mode off holds", v, 4);
    wr(0, 0, 'h05);
    set_pin(0, 1); set_pin(0, 0); rd(0, 2, v); chk("R8 enabled counts", v, 3);
  endtask

  task automatic t_underflow;
    int v;
    do_reset(); setup(2, 'h05, 1);
    set_pin(2, 1); set_pin(2, 0); rd(2, 2, v); chk("R9 decrement", v, 0);
    pin[2] = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R9 uflow high", int'(uflow[2]), 1);
    rd(2, 2, v); chk("R9 reloaded", v, 1);
    @(posedge clk); #1; chk("R9 uflow one cycle", int'(uflow[2]), 0);
    @(negedge clk); set_pin(2, 0);
  endtask

  task automatic t_cascade;
    int v;
    do_reset();
    setup(0, 'h05, 1);
    setup(1, 'h8D, 5);
    set_pin(0, 1); set_pin(0, 0); rd(1, 2, v); chk("R7 no pulse yet", v, 5);
    set_pin(1, 1); set_pin(1, 0); rd(1, 2, v); chk("R7 own pin ignored", v, 5);
    set_pin(0, 1); set_pin(0, 0); rd(1, 2, v); chk("R7 ch1 from ch0", v, 4);
    setup(5, 'h05, 0);
    setup(3, 'h81, 3);
    set_pin(5, 1); set_pin(5, 0);
    rd(3, 2, v); chk("R7 ch3 from ch5", v, 2);
    rd(4, 2, v); chk("R7 ch4 untouched", v, 0);
  endtask

  task automatic t_collision;
    int v;
    do_reset(); setup(0, 'h05, 1);
    set_pin(0, 1); set_pin(0, 0); rd(0, 2, v); chk("R10 at zero", v, 0);
    pin[0] = 1'b1;
    repeat (2) @(negedge clk);
    wr(0, 1, 9);
    rd(0, 2, v); chk("R10 collision count", v, 9);
    chk("R10 collision uflow", int'(uflow[0]), 1);
    wr(0, 1, 3);
    rd(0, 2, v); chk("R10 running write keeps count", v, 9);
    rd(0, 1, v); chk("R10 reload updated", v, 3);
    set_pin(0, 0);
  endtask

  task automatic t_spare;
    int v;
    do_reset(); setup(5, 'h45, 3);
    rd(5, 0, v); chk("R11 readback", v, 'h45);
    set_pin(5, 1); rd(5, 2, v); chk("R11 counts as normal", v, 2);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset(); t_mode_rw(); t_fall(); t_rise(); t_both(); t_rsvd();
    t_gate(); t_underflow(); t_cascade(); t_collision(); t_spare();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule